// File: doc/BRIEF.md
# Parity-Protected Opcode Decode Memory

This block holds the decode word for every opcode of an instruction fetch unit. A 10-bit address picks the entry. Its two upper bits choose one of four instruction sets, and its eight lower bits are the opcode. Each entry has a 16-bit left half and a 16-bit right half, and each half has its own write strobe. The address is sampled one cycle ahead of any access. A write commits only on the second of two back-to-back strobe cycles.

When a right half is written, the block computes three even-parity bits and places them in the top of that half. The groups cross field boundaries in both halves. To cover the left-half fields, the block keeps the left half that was written most recently. Firmware therefore writes the left half of an entry and then its right half. On every read, the block recomputes the groups from the registered read data and reports any mismatch.

A fill sequencer can load a parity-valid halt word into all 1024 entries, counting down from the top address. While it runs, external writes and further start requests are ignored. Any committed write sets a break-pending flag, and a fetch-unit reset clears it.

Top module: `opdec_ram`

## Requirements
- R1: Address bits [9:8] select the instruction set and bits [7:0] the opcode. Every one of the 1024 addresses is a separate entry, so a write to one entry leaves all others unchanged.
- R2: A half is written only when its strobe (wr_lh or wr_rh) is high on two consecutive clock edges. The commit happens on the second edge, using the address sampled one edge earlier. A strobe that lasts one cycle stores nothing.
- R3: The left half is stored exactly as written. Its layout is: dispatch address in [9:0], packed-alpha in [10], type in [12:11], [15:13] unused. The right half stores write data [12:0] as given: N in [3:0], base select in [7:4], length in [9:8], sign in [10], pause in [11], jump in [12]. Bits [15:13] are replaced by the generated parity bits pb0, pb1, pb2.
- R4: pb0 (right half bit 13) is the XOR of N[3:0], base select [1:0] and dispatch address [9:8].
- R5: pb1 (right half bit 14) is the XOR of dispatch address [7:0].
- R6: pb2 (right half bit 15) is the XOR of sign, packed-alpha, type[1:0], base select [3:2] and length[1:0]. The left-half fields come from the left half written most recently.
- R7: rd_lh and rd_rh show the entry at the address sampled on the previous edge. They are valid after the second rising edge that follows the address being presented.
- R8: parity_error is high while any of the three groups, recomputed from rd_lh and rd_rh, differs from the parity bit stored for it.
- R9: break_pending becomes 1 after any committed write. It becomes 0 after a unit_reset cycle. If both happen on the same edge, the write wins.
- R10: A fill_start pulse while idle raises busy on the next edge. busy then stays high for exactly 1024 cycles, writing addresses 1023 down to 0. Each entry receives left half 16'h0012 and right half 16'h890F: dispatch 18, length 1, pause set, N all ones, pb2 set.
- R11: While busy is high, external write strobes and fill_start have no effect.
- R12: fill_done is high for exactly one cycle, on the edge where busy falls after address 0 is written.
- R13: rst clears busy, fill_done and break_pending and aborts a fill. It leaves the stored entries unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| unit_reset | input | 1 | Fetch-unit reset; clears break_pending |
| addr | input | 10 | {instruction set, opcode}, presented one cycle before access |
| wdata | input | 16 | Write data for either half |
| wr_lh | input | 1 | Left-half write strobe (two cycles) |
| wr_rh | input | 1 | Right-half write strobe (two cycles) |
| fill_start | input | 1 | Start the halt-word fill |
| rd_lh | output | 16 | Registered left half read |
| rd_rh | output | 16 | Registered right half read |
| parity_error | output | 1 | Recomputed parity differs from stored bits |
| break_pending | output | 1 | Set by any write, cleared by unit_reset |
| busy | output | 1 | Fill sequencer running |
| fill_done | output | 1 | One-cycle pulse at the end of a fill |

## Verification
A write commits on the second strobe edge, so the bench holds the address for one cycle and then holds strobe and data across two edges before it drops them. Read data is due two rising edges after the address is driven, and parity_error follows combinationally from those registers. The bench therefore samples both on the falling edge after that second rising edge. For a fill, busy is sampled on every falling edge and counted, as are the fill_done cycles. The count must be exactly 1024 busy cycles and one done cycle, and break_pending and the reset effects are checked on the falling edge after the edge that produces them.

// File: rtl/opdec_ram_pkg.sv
package opdec_ram_pkg;
  // left half field positions
  localparam int L_DISP_LSB = 0;
  localparam int DISP_W     = 10;
  localparam int L_PA       = 10;
  localparam int L_TYPE_LSB = 11;
  // right half field positions
  localparam int R_N_LSB    = 0;
  localparam int R_MB_LSB   = 4;
  localparam int R_LEN_LSB  = 8;
  localparam int R_SIGN     = 10;
  localparam int R_PAUSE    = 11;
  localparam int R_JUMP     = 12;
  localparam int R_PB_LSB   = 13;
  localparam int PB_W       = 3;

  // three even-parity groups crossing both halves
  function automatic logic [PB_W-1:0] group_parity(
    input logic [3:0] n, input logic [3:0] mb, input logic [1:0] len,
    input logic sign, input logic [DISP_W-1:0] disp, input logic pa,
    input logic [1:0] typ);
    logic g0, g1, g2;
    g0 = ^{n, mb[1:0], disp[9:8]};
    g1 = ^disp[7:0];
    g2 = ^{sign, pa, typ, mb[3:2], len};
    return {g2, g1, g0};
  endfunction

  localparam logic [DISP_W-1:0] HALT_DISP = 10'o22;
  localparam logic [15:0] HALT_LH = 16'(HALT_DISP);
  localparam logic [15:0] HALT_RH_BASE =
    (16'hF << R_N_LSB) | (16'd1 << R_LEN_LSB) | (16'd1 << R_PAUSE);
  localparam logic [15:0] HALT_RH = HALT_RH_BASE |
    (16'(group_parity(4'hF, 4'h0, 2'd1, 1'b0, HALT_DISP, 1'b0, 2'd0)) << R_PB_LSB);
endpackage

// File: rtl/opdec_ram_par.sv
module opdec_ram_par
  import opdec_ram_pkg::*;
(
  input  logic [3:0]        n,
  input  logic [3:0]        mb,
  input  logic [1:0]        len,
  input  logic              sign,
  input  logic [DISP_W-1:0] disp,
  input  logic              pa,
  input  logic [1:0]        typ,
  output logic [PB_W-1:0]   pb
);
  always_comb pb = group_parity(n, mb, len, sign, disp, pa, typ);
endmodule

// File: rtl/opdec_ram_bank.sv
module opdec_ram_bank #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/opdec_ram_fill.sv
module opdec_ram_fill #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] waddr
);
  logic [AW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          cnt  <= '1;
        end
      end else if (cnt == '0) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign waddr = cnt;
endmodule

// File: rtl/opdec_ram.sv
module opdec_ram
  import opdec_ram_pkg::*;
#(
  parameter int SEL_W  = 2,
  parameter int OP_W   = 8,
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  unit_reset,
  input  logic [SEL_W+OP_W-1:0] addr,
  input  logic [HALF_W-1:0]     wdata,
  input  logic                  wr_lh,
  input  logic                  wr_rh,
  input  logic                  fill_start,
  output logic [HALF_W-1:0]     rd_lh,
  output logic [HALF_W-1:0]     rd_rh,
  output logic                  parity_error,
  output logic                  break_pending,
  output logic                  busy,
  output logic                  fill_done
);
  localparam int AW     = SEL_W + OP_W;
  localparam int NHALF  = 2;
  localparam int H_LEFT = 0;
  localparam int H_RGHT = 1;

  logic [AW-1:0]     addr_q;
  logic              wr_lh_q, wr_rh_q;
  logic [HALF_W-1:0] lh_shadow;
  logic [AW-1:0]     fill_addr;
  logic              ext_lh_we, ext_rh_we;
  logic              lh_we_any, rh_we_any;
  logic [HALF_W-1:0] lh_src;
  logic [PB_W-1:0]   pb_gen, pb_chk;

  logic [NHALF-1:0]  we_v;
  logic [AW-1:0]     wa_v [NHALF];
  logic [HALF_W-1:0] wd_v [NHALF];
  logic [HALF_W-1:0] rd_v [NHALF];

  opdec_ram_fill #(.AW(AW)) fill_i (
    .clk(clk), .rst(rst), .start(fill_start),
    .busy(busy), .done(fill_done), .waddr(fill_addr)
  );

  // address pipeline and two-cycle strobe qualification
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      wr_lh_q <= 1'b0;
      wr_rh_q <= 1'b0;
    end else begin
      addr_q  <= addr;
      wr_lh_q <= wr_lh;
      wr_rh_q <= wr_rh;
    end
  end

  assign ext_lh_we = wr_lh & wr_lh_q & ~busy;
  assign ext_rh_we = wr_rh & wr_rh_q & ~busy;
  assign lh_we_any = busy | ext_lh_we;
  assign rh_we_any = busy | ext_rh_we;

  // most recent left half feeds the cross-half parity groups
  always_ff @(posedge clk) begin
    if (rst)            lh_shadow <= '0;
    else if (ext_lh_we) lh_shadow <= wdata;
  end

  assign lh_src = ext_lh_we ? wdata : lh_shadow;

  opdec_ram_par gen_i (
    .n(wdata[R_N_LSB +: 4]), .mb(wdata[R_MB_LSB +: 4]),
    .len(wdata[R_LEN_LSB +: 2]), .sign(wdata[R_SIGN]),
    .disp(lh_src[L_DISP_LSB +: DISP_W]), .pa(lh_src[L_PA]),
    .typ(lh_src[L_TYPE_LSB +: 2]), .pb(pb_gen)
  );

  assign we_v[H_LEFT] = lh_we_any;
  assign we_v[H_RGHT] = rh_we_any;
  assign wa_v[H_LEFT] = busy ? fill_addr : addr_q;
  assign wa_v[H_RGHT] = busy ? fill_addr : addr_q;
  assign wd_v[H_LEFT] = busy ? HALT_LH : wdata;
  assign wd_v[H_RGHT] = busy ? HALT_RH : {pb_gen, wdata[R_PB_LSB-1:0]};

  generate
    for (genvar h = 0; h < NHALF; h++) begin : g_half
      opdec_ram_bank #(.AW(AW), .DW(HALF_W)) bank_i (
        .clk(clk), .we(we_v[h]), .waddr(wa_v[h]), .wdata(wd_v[h]),
        .raddr(addr_q), .rdata(rd_v[h])
      );
    end
  endgenerate

  assign rd_lh = rd_v[H_LEFT];
  assign rd_rh = rd_v[H_RGHT];

  opdec_ram_par chk_par_i (
    .n(rd_rh[R_N_LSB +: 4]), .mb(rd_rh[R_MB_LSB +: 4]),
    .len(rd_rh[R_LEN_LSB +: 2]), .sign(rd_rh[R_SIGN]),
    .disp(rd_lh[L_DISP_LSB +: DISP_W]), .pa(rd_lh[L_PA]),
    .typ(rd_lh[L_TYPE_LSB +: 2]), .pb(pb_chk)
  );

  assign parity_error = |(pb_chk ^ rd_rh[R_PB_LSB +: PB_W]);

  // break flag: a write wins over a same-edge unit reset
  always_ff @(posedge clk) begin
    if (rst)                         break_pending <= 1'b0;
    else if (lh_we_any | rh_we_any)  break_pending <= 1'b1;
    else if (unit_reset)             break_pending <= 1'b0;
  end
endmodule

// File: rtl/opdec_ram_chk.sv
module opdec_ram_chk (
  input logic clk,
  input logic rst,
  input logic unit_reset,
  input logic lh_we,
  input logic rh_we,
  input logic break_pending,
  input logic busy,
  input logic fill_done
);
  p_write_sets_break_r9: assert property (@(posedge clk) disable iff (rst)
    (lh_we || rh_we) |=> break_pending);

  p_unit_reset_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (unit_reset && !lh_we && !rh_we) |=> !break_pending);

  p_done_single_r12: assert property (@(posedge clk) disable iff (rst)
    fill_done |=> !fill_done);

  p_done_after_busy_r12: assert property (@(posedge clk) disable iff (rst)
    fill_done |-> (!busy && $past(busy)));

  p_busy_end_done_r10: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> fill_done);

  p_reset_state_r13: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !fill_done && !break_pending));
endmodule

bind opdec_ram opdec_ram_chk chk_i (
  .clk(clk), .rst(rst), .unit_reset(unit_reset),
  .lh_we(lh_we_any), .rh_we(rh_we_any),
  .break_pending(break_pending), .busy(busy), .fill_done(fill_done)
);

// File: tb/opdec_ram_tb.sv
module opdec_ram_tb_top;
  localparam time TCK = 20ns;
  localparam int  NV  = 5;
  // {addr, left half, right half in, right half expected}
  localparam logic [57:0] VEC [NV] = '{
    {10'h001, 16'h000D, 16'h010F, 16'hC10F},
    {10'h1A7, 16'h17FF, 16'hF663, 16'hB663},
    {10'h3FF, 16'h0A00, 16'h0BF0, 16'hABF0},
    {10'h205, 16'h04AA, 16'h1118, 16'h1118},
    {10'h005, 16'h0001, 16'h0000, 16'h4000}
  };

  logic clk = 1'b0, rst = 1'b1, unit_reset = 1'b0;
  logic [9:0] addr = '0;
  logic [15:0] wdata = '0;
  logic wr_lh = 1'b0, wr_rh = 1'b0, fill_start = 1'b0;
  logic [15:0] rd_lh, rd_rh;
  logic parity_error, break_pending, busy, fill_done;

  int checks = 0, errors = 0;
  int busy_cnt = 0, done_cnt = 0;
  bit count_en = 1'b0;

  always #(TCK/2) clk = ~clk;

  opdec_ram dut_i (
    .clk(clk), .rst(rst), .unit_reset(unit_reset), .addr(addr),
    .wdata(wdata), .wr_lh(wr_lh), .wr_rh(wr_rh), .fill_start(fill_start),
    .rd_lh(rd_lh), .rd_rh(rd_rh), .parity_error(parity_error),
    .break_pending(break_pending), .busy(busy), .fill_done(fill_done)
  );

  always @(negedge clk) if (count_en) begin
    if (busy) busy_cnt++;
    if (fill_done) done_cnt++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit right, input logic [9:0] a, input logic [15:0] d,
                    input int ncyc, input bit ur_last);
    @(negedge clk); addr = a; wr_lh = 0; wr_rh = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      wdata = d;
      if (right) wr_rh = 1; else wr_lh = 1;
      if (ur_last && i == ncyc - 1) unit_reset = 1;
    end
    @(negedge clk); wr_lh = 0; wr_rh = 0; unit_reset = 0;
  endtask

  task automatic rd(input logic [9:0] a);
    @(negedge clk); addr = a;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(TCK * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R13 reset busy", busy, 0);
    check("R13 reset done", fill_done, 0);
    check("R9 reset break", break_pending, 0);

    // table walk: R3..R7 write-then-read
    foreach (VEC[i]) begin
      wr(0, VEC[i][57:48], VEC[i][47:32], 2, 0);
      wr(1, VEC[i][57:48], VEC[i][31:16], 2, 0);
      rd(VEC[i][57:48]);
      check("R3 R7 left half", rd_lh, VEC[i][47:32]);
      check("R4 R5 R6 right half parity", rd_rh, VEC[i][15:0]);
      check("R8 clean entry", parity_error, 0);
    end
    // R1: entries stay independent (sets 0 and 2 share opcode 5)
    foreach (VEC[i]) begin
      rd(VEC[i][57:48]);
      check("R1 lh retained", rd_lh, VEC[i][47:32]);
      check("R1 rh retained", rd_rh, VEC[i][15:0]);
    end
    check("R9 break after write", break_pending, 1);

    // R9: unit reset clears
    @(negedge clk); unit_reset = 1;
    @(negedge clk); unit_reset = 0;
    check("R9 cleared by unit reset", break_pending, 0);

    // R2: one-cycle strobe stores nothing and does not set break
    wr(0, 10'h001, 16'h1FFF, 1, 0);
    rd(10'h001);
    check("R2 single strobe ignored", rd_lh, 16'h000D);
    check("R2 no break", break_pending, 0);

    // R9: write and unit reset on the same edge, write wins
    wr(1, 10'h005, 16'h0000, 2, 1);
    check("R9 write wins", break_pending, 1);

    // R8: change left half only, flipping one pb1 bit
    wr(0, 10'h001, 16'h000C, 2, 0);
    rd(10'h001);
    check("R8 lh updated", rd_lh, 16'h000C);
    check("R8 mismatch flagged", parity_error, 1);

    // R10-R12: fill
    busy_cnt = 0; done_cnt = 0; count_en = 1;
    @(negedge clk); fill_start = 1;
    @(negedge clk); fill_start = 0;
    check("R10 busy rises", busy, 1);
    wr(0, 10'h3FF, 16'h1234, 2, 0);   // R11 ignored write
    @(negedge clk); fill_start = 1;   // R11 ignored restart
    @(negedge clk); fill_start = 0;
    for (int k = 0; k < 1100 && busy; k++) @(negedge clk);
    repeat (4) @(negedge clk);
    count_en = 0;
    check("R10 busy length", busy_cnt, 1024);
    check("R12 done pulse count", done_cnt, 1);
    check("R9 fill sets break", break_pending, 1);
    for (int j = 0; j < 4; j++) begin
      logic [9:0] a;
      a = (j == 0) ? 10'h000 : (j == 1) ? 10'h3FF : (j == 2) ? 10'h1A7 : 10'h205;
      rd(a);
      check("R10 R11 halt lh", rd_lh, 16'h0012);
      check("R10 halt rh", rd_rh, 16'h890F);
      check("R10 halt parity ok", parity_error, 0);
    end

    // R13: reset keeps memory
    @(negedge clk); rst = 1;
    @(negedge clk);
    @(negedge clk); rst = 0;
    check("R13 break cleared", break_pending, 0);
    rd(10'h1A7);
    check("R13 memory kept", rd_rh, 16'h890F);

    // R13: reset aborts a fill
    busy_cnt = 0; done_cnt = 0; count_en = 1;
    @(negedge clk); fill_start = 1;
    @(negedge clk); fill_start = 0;
    repeat (10) @(negedge clk);
    rst = 1;
    @(negedge clk);
    @(negedge clk); rst = 0;
    check("R13 busy aborted", busy, 0);
    repeat (4) @(negedge clk);
    count_en = 0;
    check("R13 no done after abort", done_cnt, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule